// File: doc/BRIEF.md
# Sampling Converter Read Controller

This block sits on the host side of a 12-bit successive-approximation converter with a parallel, select-gated data bus. On a start request it pulls the select and read/convert lines low together for a set number of clocks, which begins a conversion. The converter then drops its busy line while converting and raises it when the result is ready.

The controller passes busy through a synchronizer and waits for its rising edge. It then reads the result in one of two ways. In word mode it makes one access with the high-byte line low and takes all twelve data lines. In split mode only the low eight data lines are wired. The controller first reads with high-byte high, where the top four result bits appear on lines 3..0. It then reads with high-byte low and takes bits 7..0. Both pieces are merged into one 12-bit sample.

The sample leaves with a one-cycle valid strobe, in raw offset-binary form and in two's-complement form. If busy never rises, a programmable timeout ends the attempt with an error pulse. The converter needs a sampling period of at least 3 µs, which the host enforces by how often it requests a start.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While and after synchronous reset (rst_n low), cs_n and rc_n are 1, hbe is 0, smp_valid and err_timeout are 0, and ctrl_ready is 1.
- R2: A start_req seen while ctrl_ready is 1 and the synchronized busy is high holds cs_n and rc_n both low for exactly STROBE_CYC clocks with hbe 0. A start_req while synchronized busy is low produces no rc_n low.
- R3: Busy is used only after a SYNC_STAGES-flop synchronizer (default 2). The read access (cs_n low, rc_n high) begins on the second clock edge after the first edge that samples busy high.
- R4: In word mode (split_mode 0 at the start), one read with hbe 0 is made, and smp_code equals data_in[11:0] from that read.
- R5: In split mode (split_mode 1 at the start), two reads are made. The first has hbe 1 and supplies result bits 11..8 from data_in[3:0]. The second has hbe 0 and supplies bits 7..0 from data_in[7:0]. data_in[11:8] is ignored in split mode.
- R6: hbe is 0 whenever the controller is idle, so it is 0 when smp_valid pulses and before the next start.
- R7: smp_valid is high for exactly one clock per completed conversion. smp_twos equals smp_code with bit 11 inverted.
- R8: start_req while ctrl_ready is 0 is ignored. Extra requests during a conversion start no further conversion and yield no extra valid pulse.
- R9: If busy does not rise before the wait expires, err_timeout pulses for one clock, timeout_lim+1 clock edges after the edge that accepts the start. No valid pulse occurs, all lines return idle, and the next start works normally. timeout_lim must exceed STROBE_CYC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | Request one conversion |
| split_mode | input | 1 | 0: 12-bit word read, 1: two 8-bit reads |
| timeout_lim | input | TO_W | Clocks allowed from start until busy rises |
| busy | input | 1 | Converter busy, low while converting (asynchronous) |
| data_in | input | DATA_W | Converter data lines |
| cs_n | output | 1 | Converter select, active low |
| rc_n | output | 1 | Read (high) / convert (low) |
| hbe | output | 1 | High-byte enable |
| smp_valid | output | 1 | One-cycle strobe for a new sample |
| smp_code | output | DATA_W | Sample, offset binary |
| smp_twos | output | DATA_W | Sample, two's complement |
| err_timeout | output | 1 | One-cycle pulse when busy never rose |
| ctrl_ready | output | 1 | Idle and able to accept a start |

## Verification
In split mode the bench model drives the unused upper four data lines with the inverted high nibble. A design that assembled the high part from data_in[11:8], or in the wrong byte order, would return corrupted samples on codes such as 0xA5C. The bench measures the cycles from busy rising to the read select. A controller that skipped the synchronizer, or acted on the level of busy instead of its edge, would read one or more cycles early. The bench also holds busy low at a request and fires extra requests during a conversion; a design with a loose start guard would then make forbidden starts or emit extra valid pulses. Exact timeout timing and recovery afterwards catch off-by-one counters and a controller that is left stuck.

// File: rtl/adc_rd_pkg.sv
// Shared types for the converter read controller.
// Assumes: one sequencer per converter; the encodings are internal only.
package adc_rd_pkg;

    // Sequencer phases of one conversion-and-read cycle.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_STRB  = 3'd1,
        ST_WAIT  = 3'd2,
        ST_RD_HI = 3'd3,
        ST_RD_LO = 3'd4,
        ST_DONE  = 3'd5,
        ST_FAIL  = 3'd6
    } rd_state_t;

    // Larger of two non-negative values, used to size shared counters.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_busy_sync.sv
// Brings the asynchronous busy line into the clock domain and detects its
// rising edge (end of conversion).
// Assumes: STAGES >= 2; busy idles high, so the flops reset to 1 and reset
// release raises no false edge.
module adc_busy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_raw,
    output logic busy_s,
    output logic busy_rise
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Shift busy through the synchronizer chain and keep one extra copy for edge detect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            last_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], busy_raw};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign busy_s    = sync_q[STAGES-1];
    assign busy_rise = busy_s & ~last_q;

endmodule

// File: rtl/adc_phase_timer.sv
// Down-counter that times the strobe and read phases.
// Loading N-1 on the edge that enters a phase makes the phase last N clocks.
// expired is high in the last clock of the phase.
// Assumes: load_val fits in W bits.
module adc_phase_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    // Reload on phase entry, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/adc_word_asm.sv
// Builds the sample from one full-width read or from two byte-wide reads.
// In the high read the top DATA_W-BUS_W bits arrive on the lowest data lines.
// Also produces the two's-complement view by inverting the MSB.
// Assumes: DATA_W > BUS_W and DATA_W - BUS_W <= BUS_W.
module adc_word_asm #(
    parameter int DATA_W = 12,
    parameter int BUS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_hi,
    input  logic              cap_lo,
    input  logic              split,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] code,
    output logic [DATA_W-1:0] twos
);

    localparam int HI_W = DATA_W - BUS_W;

    logic [DATA_W-1:0] code_q;

    // Capture the high part, the low byte, or the whole word, as the sequencer asks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (cap_hi) begin
            code_q[DATA_W-1:BUS_W] <= data_in[HI_W-1:0];
        end else if (cap_lo) begin
            if (split) begin
                code_q[BUS_W-1:0] <= data_in[BUS_W-1:0];
            end else begin
                code_q <= data_in;
            end
        end
    end

    assign code = code_q;
    assign twos = {~code_q[DATA_W-1], code_q[DATA_W-2:0]};

endmodule

// File: rtl/adc_rd_ctrl.sv
// Host-side read controller for a parallel-bus successive-approximation converter.
// It starts a conversion, waits for busy to rise, reads the result as a word
// or as two bytes, and emits the sample with a one-cycle valid strobe.
// Assumes: conversion time is longer than STROBE_CYC + SYNC_STAGES clocks;
// timeout_lim > STROBE_CYC; data_in is settled RD_SETUP clocks after select.
module adc_rd_ctrl #(
    parameter int DATA_W      = 12,
    parameter int BUS_W       = 8,
    parameter int STROBE_CYC  = 4,
    parameter int RD_SETUP    = 2,
    parameter int TO_W        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              split_mode,
    input  logic [TO_W-1:0]   timeout_lim,
    input  logic              busy,
    input  logic [DATA_W-1:0] data_in,
    output logic              cs_n,
    output logic              rc_n,
    output logic              hbe,
    output logic              smp_valid,
    output logic [DATA_W-1:0] smp_code,
    output logic [DATA_W-1:0] smp_twos,
    output logic              err_timeout,
    output logic              ctrl_ready
);

    import adc_rd_pkg::*;

    localparam int TMR_MAX = max2(STROBE_CYC, RD_SETUP);
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam logic [TMR_W-1:0] STRB_LD = TMR_W'(STROBE_CYC - 1);
    localparam logic [TMR_W-1:0] RD_LD   = TMR_W'(RD_SETUP - 1);

    rd_state_t         state_q, state_nx;
    logic              split_q;
    logic [TO_W-1:0]   to_cnt_q;
    logic              busy_s, busy_rise;
    logic              tmr_load, tmr_exp;
    logic [TMR_W-1:0]  tmr_val;
    logic              cap_hi, cap_lo;
    logic              accept;

    adc_busy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy_raw  (busy),
        .busy_s    (busy_s),
        .busy_rise (busy_rise)
    );

    adc_phase_timer #(.W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    adc_word_asm #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_asm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_hi  (cap_hi),
        .cap_lo  (cap_lo),
        .split   (split_q),
        .data_in (data_in),
        .code    (smp_code),
        .twos    (smp_twos)
    );

    // Start only from idle, and only when the converter reports not busy.
    assign accept = (state_q == ST_IDLE) && start_req && busy_s;

    // Next-phase decode, timer reloads and capture strobes.
    always_comb begin
        state_nx = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cap_hi   = 1'b0;
        cap_lo   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_nx = ST_STRB;
                    tmr_load = 1'b1;
                    tmr_val  = STRB_LD;
                end
            end
            ST_STRB: begin
                if (tmr_exp) state_nx = ST_WAIT;
            end
            ST_WAIT: begin
                if (busy_rise) begin
                    state_nx = split_q ? ST_RD_HI : ST_RD_LO;
                    tmr_load = 1'b1;
                    tmr_val  = RD_LD;
                end else if (to_cnt_q >= timeout_lim) begin
                    state_nx = ST_FAIL;
                end
            end
            ST_RD_HI: begin
                if (tmr_exp) begin
                    cap_hi   = 1'b1;
                    state_nx = ST_RD_LO;
                    tmr_load = 1'b1;
                    tmr_val  = RD_LD;
                end
            end
            ST_RD_LO: begin
                if (tmr_exp) begin
                    cap_lo   = 1'b1;
                    state_nx = ST_DONE;
                end
            end
            ST_DONE: state_nx = ST_IDLE;
            ST_FAIL: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Phase register and read-mode latch taken at the start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            split_q <= 1'b0;
        end else begin
            state_q <= state_nx;
            if (accept) split_q <= split_mode;
        end
    end

    // Clocks since the start, saturating; cleared while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == ST_IDLE) begin
            to_cnt_q <= '0;
        end else if ((state_q == ST_STRB || state_q == ST_WAIT) && to_cnt_q != '1) begin
            to_cnt_q <= to_cnt_q + 1'b1;
        end
    end

    // Converter lines and host strobes decoded straight from the phase register.
    always_comb begin
        cs_n        = !(state_q == ST_STRB || state_q == ST_RD_HI || state_q == ST_RD_LO);
        rc_n        = (state_q != ST_STRB);
        hbe         = (state_q == ST_RD_HI);
        smp_valid   = (state_q == ST_DONE);
        err_timeout = (state_q == ST_FAIL);
        ctrl_ready  = (state_q == ST_IDLE);
    end

endmodule

// File: rtl/adc_rd_ctrl_chk.sv
// Protocol checker for the converter read controller, bound to every instance.
// Assumes: observes ports only.
module adc_rd_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic rc_n,
    input logic hbe,
    input logic smp_valid,
    input logic err_timeout,
    input logic ctrl_ready
);

    // A conversion edge only happens with select low and high-byte low.
    p_start_qual_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rc_n) |-> (!cs_n && !hbe));

    // The convert strobe is never driven without select.
    p_strobe_selected_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rc_n |-> !cs_n);

    // High-byte enable only during a selected read.
    p_hbe_in_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hbe |-> (!cs_n && rc_n));

    // Idle means all converter lines are released, hbe low.
    p_idle_lines_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_ready |-> (cs_n && rc_n && !hbe));

    // Valid is a single-clock pulse.
    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> !smp_valid);

    // A cycle never ends both with a sample and with a timeout.
    p_outcome_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(smp_valid && err_timeout));

    // Error is a single-clock pulse followed by idle.
    p_err_then_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |=> (ctrl_ready && !err_timeout));

endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .rc_n        (rc_n),
    .hbe         (hbe),
    .smp_valid   (smp_valid),
    .err_timeout (err_timeout),
    .ctrl_ready  (ctrl_ready)
);

// File: tb/adc_rd_ctrl_tb.sv
// Self-checking bench: a behavioural converter model, a vector table walked
// by one loop, then directed tests for reset, start guard and timeout.
module adc_rd_ctrl_tb;

    localparam int STROBE = 4;
    localparam int CONV_CYC = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_req = 1'b0;
    logic        split_mode = 1'b0;
    logic [15:0] timeout_lim = 16'd200;
    logic        busy;
    logic [11:0] data_in;
    logic        cs_n, rc_n, hbe, smp_valid, err_timeout, ctrl_ready;
    logic [11:0] smp_code, smp_twos;

    int vectors = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2.5ns clk = ~clk;

    adc_rd_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .split_mode(split_mode),
        .timeout_lim(timeout_lim), .busy(busy), .data_in(data_in),
        .cs_n(cs_n), .rc_n(rc_n), .hbe(hbe), .smp_valid(smp_valid),
        .smp_code(smp_code), .smp_twos(smp_twos), .err_timeout(err_timeout),
        .ctrl_ready(ctrl_ready)
    );

    // ---------------- converter model ----------------
    logic        busy_m = 1'b1;
    int          busy_cnt = 0;
    logic [11:0] latched = 12'h000;
    logic [11:0] next_code = 12'h000;
    logic        mute = 1'b0;
    logic        hold_low = 1'b0;
    logic        rc_mq = 1'b1;
    int          bad_starts = 0;
    int          rc_falls = 0;

    assign busy = busy_m & ~hold_low;

    always @(posedge clk) begin
        rc_mq <= rc_n;
        if (rc_mq && !rc_n && !cs_n) begin
            rc_falls <= rc_falls + 1;
            if (hbe || !busy) begin
                bad_starts <= bad_starts + 1;
            end else if (!mute) begin
                busy_m   <= 1'b0;
                busy_cnt <= CONV_CYC;
            end
        end else if (!busy_m) begin
            if (busy_cnt == 0) begin
                busy_m  <= 1'b1;
                latched <= next_code;
            end else begin
                busy_cnt <= busy_cnt - 1;
            end
        end
    end

    // Split mode: upper four lines unconnected, modelled as the inverted nibble.
    assign data_in = cs_n ? 12'h000 :
                     hbe  ? {~latched[11:8], 4'h0, latched[11:8]} :
                     split_mode ? {~latched[11:8], latched[7:0]} : latched;

    // ---------------- monitor ----------------
    int   cyc = 0;
    int   rc_run = 0, rc_width = 0;
    int   hbe_rises = 0, valid_cnt = 0;
    int   rise_cyc = 0, rd_cyc = 0;
    logic hbe_q = 1'b0, busy_q = 1'b1, cs_q = 1'b1;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rc_n) rc_run <= rc_run + 1;
        else if (rc_run != 0) begin
            rc_width <= rc_run;
            rc_run   <= 0;
        end
        if (hbe && !hbe_q) hbe_rises <= hbe_rises + 1;
        if (smp_valid) valid_cnt <= valid_cnt + 1;
        if (busy && !busy_q) rise_cyc <= cyc;
        if (!cs_n && cs_q && rc_n) rd_cyc <= cyc;
        hbe_q  <= hbe;
        busy_q <= busy;
        cs_q   <= cs_n;
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic pulse_start();
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
    endtask

    task automatic run_conv(input logic sp, input logic [11:0] code);
        int  h0;
        bit  got;
        logic [11:0] exp_twos;
        split_mode = sp;
        next_code  = code;
        h0 = hbe_rises;
        pulse_start();
        got = 1'b0;
        for (int i = 0; i < 400; i++) begin
            if (smp_valid) begin
                got = 1'b1;
                break;
            end
            @(negedge clk);
        end
        exp_twos = {~code[11], code[10:0]};
        chk(got, sp ? "R5" : "R4", "valid seen", got, 1);
        chk(smp_code == code, sp ? "R5" : "R4", "smp_code", smp_code, code);
        chk(smp_twos == exp_twos, "R7", "smp_twos", smp_twos, exp_twos);
        chk(hbe == 1'b0, "R6", "hbe at valid", hbe, 0);
        chk(rd_cyc - rise_cyc == 3, "R3", "busy rise to read", rd_cyc - rise_cyc, 3);
        @(negedge clk);
        chk(smp_valid == 1'b0, "R7", "valid width", smp_valid, 0);
        chk(rc_width == STROBE, "R2", "rc_n low clocks", rc_width, STROBE);
        chk(hbe_rises - h0 == int'(sp), "R5", "high reads", hbe_rises - h0, int'(sp));
        chk(bad_starts == 0, "R2", "forbidden starts", bad_starts, 0);
    endtask

    // {split, code}
    localparam logic [12:0] VEC [10] = '{
        {1'b0, 12'h000}, {1'b0, 12'hFFF}, {1'b0, 12'h800}, {1'b0, 12'h7FF},
        {1'b0, 12'h5A3}, {1'b1, 12'hA5C}, {1'b1, 12'h3F0}, {1'b1, 12'h801},
        {1'b1, 12'h0FF}, {1'b1, 12'hF00}
    };

    // ---------------- watchdog ----------------
    initial begin
        #750us;
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        int v0, r0, n;
        bit got;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(cs_n && rc_n, "R1", "cs_n/rc_n in reset", {cs_n, rc_n}, 3);
        chk(!hbe && !smp_valid && !err_timeout, "R1", "hbe/valid/err in reset",
            {hbe, smp_valid, err_timeout}, 0);
        chk(ctrl_ready, "R1", "ready in reset", ctrl_ready, 1);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // Vector table: word and split reads (R2..R7)
        foreach (VEC[i]) begin
            run_conv(VEC[i][12], VEC[i][11:0]);
            repeat (3) @(negedge clk);
        end

        // R2: start refused while busy is low
        hold_low = 1'b1;
        repeat (4) @(negedge clk);
        r0 = rc_falls;
        pulse_start();
        repeat (20) @(negedge clk);
        chk(rc_falls == r0, "R2", "start while busy low", rc_falls - r0, 0);
        chk(ctrl_ready, "R2", "still ready", ctrl_ready, 1);
        hold_low = 1'b0;
        repeat (4) @(negedge clk);

        // R8: extra requests during a conversion are ignored
        split_mode = 1'b0;
        next_code  = 12'h6C3;
        v0 = valid_cnt;
        r0 = rc_falls;
        pulse_start();
        for (int k = 0; k < 3; k++) begin
            repeat (8) @(negedge clk);
            pulse_start();
        end
        repeat (120) @(negedge clk);
        chk(valid_cnt - v0 == 1, "R8", "valid pulses", valid_cnt - v0, 1);
        chk(rc_falls - r0 == 1, "R8", "conversions started", rc_falls - r0, 1);
        chk(smp_code == 12'h6C3, "R8", "sample after extra requests", smp_code, 12'h6C3);

        // R9: timeout when busy never rises
        mute = 1'b1;
        timeout_lim = 16'd30;
        v0 = valid_cnt;
        start_req = 1'b1;
        n = 0;
        got = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            start_req = 1'b0;
            n++;
            if (err_timeout) begin
                got = 1'b1;
                break;
            end
        end
        chk(got, "R9", "err pulse seen", got, 1);
        chk(n == 32, "R9", "err timing", n, 32);
        @(negedge clk);
        chk(!err_timeout, "R9", "err width", err_timeout, 0);
        chk(ctrl_ready && cs_n && rc_n && !hbe, "R9", "lines idle after err",
            {ctrl_ready, cs_n, rc_n, hbe}, 4'hE);
        chk(valid_cnt == v0, "R9", "no valid on timeout", valid_cnt - v0, 0);
        mute = 1'b0;
        timeout_lim = 16'd200;
        repeat (4) @(negedge clk);
        run_conv(1'b1, 12'h9E7);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule